// File: doc/BRIEF.md
# Character Display 4-Bit Bring-Up and Text Sequencer

This block drives a character display module over a four-bit nibble bus: a strobe, a register-select line, a read/write line, four data lines out and four data lines in. On a start pulse it first runs the power-up nibble train on fixed delays, with no busy checking. It then switches the module into four-bit, two-line operation and runs the setup commands. Finally it writes two lines of text taken from a small internal buffer. All delays come from one shared down-counter, scaled by a clock-frequency parameter.

Each byte goes out as two nibbles, upper half first, with a short gap between them. After a settle delay the block polls the module's status byte until the busy bit clears. That poll is bounded: if the module stays busy for the whole allowance, the error output rises and the run stops. Once both lines are written, the block pulses done and waits in a ready state. From there a start pulse re-runs everything, and a sleep or wake request sends the display-off or display-on command.

The text buffer is a block-RAM style store. The host fills it through a simple write port while the sequencer is idle.

Top module: `chardisp_init_seq`

## Requirements
- R1: After reset the strobe is low, done and error are low, and no bus cycle happens until start is pulsed.
- R2: A start pulse first writes nibble 0x3 three times and then nibble 0x2, all with select 0 and read/write 0. The gap after the first of these is at least 5 ms and after each of the others at least 100 us. No read cycle occurs in this phase.
- R3: After the power-up train the block sends the command bytes 0x28, 0x0C, 0x06, 0x01 and 0x02 in that order, each with select 0.
- R4: Every byte goes out as its bits 7:4 on one strobe, then its bits 3:0 on the next strobe. The two strobes are at least 10 us apart, and the upper half of the next byte starts at least 100 us after the lower half of the previous one.
- R5: Each status poll is two read strobes (read/write 1, select 0), upper nibble first. Only data-in bit 3 of the upper read (status bit 7) means busy; all other returned bits are ignored.
- R6: A poll that reads not-busy ends the wait and the sequence moves on. A clear reading on the 50th poll still counts as success.
- R7: If 50 polls in a row all read busy, error rises, no further write strobe is issued and done does not pulse. Error stays high until the next start pulse clears it.
- R8: Line 0 is written after command 0x80 and line 1 after command 0xA8 (0x80 with address 0x28). Characters go out with select 1.
- R9: Buffer address bit 6 picks the line and bits 5:0 the column. A line ends at a zero byte, which is not sent, or after 40 characters, whichever comes first.
- R10: Done is high for exactly one cycle, after the status poll of the last line-1 character (or of the line-1 address command when line 1 is empty) has read not-busy.
- R11: In the ready state a sleep request sends byte 0x08 and a wake request sends byte 0x0C. Each is followed by its status poll and ends with a one-cycle done pulse.
- R12: Data, select and read/write do not change while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: run bring-up and text write |
| sleep_req | input | 1 | Pulse in ready state: display off |
| wake_req | input | 1 | Pulse in ready state: display on |
| txt_we | input | 1 | Text buffer write enable |
| txt_addr | input | 7 | Text buffer address (bit 6 line, 5:0 column) |
| txt_wdata | input | 8 | Text buffer write byte |
| lcd_en | output | 1 | Bus strobe |
| lcd_rs | output | 1 | Register select (0 command/status, 1 data) |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_dout | output | 4 | Nibble toward the module |
| lcd_din | input | 4 | Nibble from the module |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Busy-poll timeout, held until next start |

## Verification
The module model answers each byte with a chosen number of busy polls: 0, 3, 49 and 50. These separate a block that never polls, one that stops early, one that gives up one poll too soon, and one that never gives up. Non-busy status returns set bits 6:4 and the whole lower nibble, which exposes a wrong busy bit. Texts are checked with an immediate terminator, a short string and a full 40-character line with no terminator, which separate zero detection from the length limit. The minimum gaps between write strobes are timed to catch shortened delays.

// File: rtl/cds_pkg.sv
package cds_pkg;

  localparam logic [7:0] CMD_DDRAM    = 8'h80;
  localparam logic [7:0] CMD_DISP_OFF = 8'h08;
  localparam logic [7:0] CMD_DISP_ON  = 8'h0C;
  localparam int         N_SETUP      = 5;

  typedef enum logic [1:0] {SRC_SETUP, SRC_ADDR, SRC_TEXT, SRC_PWR} src_t;

  typedef enum logic [4:0] {
    S_IDLE, S_RST_NIB, S_RST_ACK, S_RST_WAIT, S_NEXT, S_FETCH, S_FETCH_W,
    S_LINE_END, S_HI, S_HI_ACK, S_GAP, S_LO_ACK, S_WAIT, S_PH_ACK, S_PL_ACK,
    S_READY
  } seq_state_t;

  // setup byte list, sent in this order after the switch to nibble mode
  function automatic logic [7:0] setup_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h28;
      3'd1:    return 8'h0C;
      3'd2:    return 8'h06;
      3'd3:    return 8'h01;
      default: return 8'h02;
    endcase
  endfunction

endpackage

// File: rtl/cds_delay.sv
module cds_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // a loaded count only ever falls by one per cycle (R2, R4)
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cds_nib_bus.sv
module cds_nib_bus #(
  parameter int EN_CYC = 4,
  localparam int CW = $clog2(EN_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       rd,
  input  logic       rs,
  input  logic [3:0] wnib,
  output logic       ack,
  output logic [3:0] rnib,
  output logic       lcd_en,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic [3:0] lcd_dout,
  input  logic [3:0] lcd_din
);
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_HIGH, B_HOLD} bus_state_t;
  bus_state_t bst;
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst <= B_IDLE; hcnt <= '0; ack <= 1'b0; rnib <= '0;
      lcd_en <= 1'b0; lcd_rs <= 1'b0; lcd_rw <= 1'b0; lcd_dout <= '0;
    end else begin
      ack <= 1'b0;
      case (bst)
        B_IDLE: if (req) begin
          lcd_rs   <= rs;
          lcd_rw   <= rd;
          lcd_dout <= rd ? 4'h0 : wnib;
          bst      <= B_SETUP;
        end
        B_SETUP: begin
          lcd_en <= 1'b1;
          hcnt   <= CW'(EN_CYC - 1);
          bst    <= B_HIGH;
        end
        B_HIGH: begin
          if (hcnt == '0) begin
            lcd_en <= 1'b0;
            if (lcd_rw) rnib <= lcd_din;
            bst <= B_HOLD;
          end else begin
            hcnt <= hcnt - 1'b1;
          end
        end
        default: begin
          lcd_rw <= 1'b0;
          ack    <= 1'b1;
          bst    <= B_IDLE;
        end
      endcase
    end
  end

  // bus lines hold still for the whole strobe (R12)
  p_bus_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_dout) && $stable(lcd_rs) && $stable(lcd_rw)));
  // an acknowledge only follows a finished strobe
  p_ack_after_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    ack |-> !lcd_en);
endmodule

// File: rtl/cds_textbuf.sv
module cds_textbuf #(
  parameter int AW = 7,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/chardisp_init_seq.sv
module chardisp_init_seq
  import cds_pkg::*;
#(
  parameter int         CLK_HZ     = 50_000_000,
  parameter int         EN_CYC     = 4,
  parameter int         MAX_POLLS  = 50,
  parameter int         LINE_LEN   = 40,
  parameter logic [6:0] LINE1_BASE = 7'h28,
  localparam int COL_W  = $clog2(LINE_LEN),
  localparam int AW     = COL_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          txt_we,
  input  logic [AW-1:0] txt_addr,
  input  logic [7:0]    txt_wdata,
  output logic          lcd_en,
  output logic          lcd_rs,
  output logic          lcd_rw,
  output logic [3:0]    lcd_dout,
  input  logic [3:0]    lcd_din,
  output logic          done,
  output logic          error
);
  localparam int T_LONG  = (CLK_HZ / 200 > 0)    ? CLK_HZ / 200    : 1;
  localparam int T_SET   = (CLK_HZ / 10000 > 0)  ? CLK_HZ / 10000  : 1;
  localparam int T_GAP   = (CLK_HZ / 100000 > 0) ? CLK_HZ / 100000 : 1;
  localparam int TW      = $clog2(T_LONG + 1);
  localparam int PW      = $clog2(MAX_POLLS + 1);

  seq_state_t    state;
  src_t          src;
  logic [1:0]    rst_idx;
  logic [2:0]    set_idx;
  logic          line;
  logic [COL_W:0] col;
  logic [7:0]    cur_byte;
  logic          cur_rs;
  logic [PW-1:0] poll_cnt;
  logic          stat_busy;

  logic          nb_req, nb_rd, nb_rs, nb_ack;
  logic [3:0]    nb_wnib, nb_rnib;
  logic          tmr_load, tmr_zero, tmr_free;
  logic [TW-1:0] tmr_val;
  logic [7:0]    rd_byte;
  logic          unused_stat_low;

  assign tmr_free        = tmr_zero && !tmr_load;
  assign unused_stat_low = ^nb_rnib[2:0];

  cds_delay #(.W(TW)) u_delay (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  cds_nib_bus #(.EN_CYC(EN_CYC)) u_bus (
    .clk(clk), .rst(rst), .req(nb_req), .rd(nb_rd), .rs(nb_rs), .wnib(nb_wnib),
    .ack(nb_ack), .rnib(nb_rnib), .lcd_en(lcd_en), .lcd_rs(lcd_rs),
    .lcd_rw(lcd_rw), .lcd_dout(lcd_dout), .lcd_din(lcd_din)
  );

  cds_textbuf #(.AW(AW), .DW(8)) u_text (
    .clk(clk), .we(txt_we), .waddr(txt_addr), .wdata(txt_wdata),
    .raddr({line, col[COL_W-1:0]}), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; src <= SRC_SETUP; rst_idx <= '0; set_idx <= '0;
      line <= 1'b0; col <= '0; cur_byte <= '0; cur_rs <= 1'b0;
      poll_cnt <= '0; stat_busy <= 1'b0;
      nb_req <= 1'b0; nb_rd <= 1'b0; nb_rs <= 1'b0; nb_wnib <= '0;
      tmr_load <= 1'b0; tmr_val <= '0; done <= 1'b0; error <= 1'b0;
    end else begin
      nb_req   <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE, S_READY: begin
          if (start) begin
            error   <= 1'b0;
            rst_idx <= '0;
            state   <= S_RST_NIB;
          end else if (state == S_READY && (sleep_req || wake_req)) begin
            cur_byte <= sleep_req ? CMD_DISP_OFF : CMD_DISP_ON;
            cur_rs   <= 1'b0;
            src      <= SRC_PWR;
            state    <= S_HI;
          end
        end
        // blind power-up train: no status reads here
        S_RST_NIB: begin
          nb_req  <= 1'b1; nb_rd <= 1'b0; nb_rs <= 1'b0;
          nb_wnib <= (rst_idx == 2'd3) ? 4'h2 : 4'h3;
          state   <= S_RST_ACK;
        end
        S_RST_ACK: if (nb_ack) begin
          tmr_load <= 1'b1;
          tmr_val  <= (rst_idx == 2'd0) ? TW'(T_LONG) : TW'(T_SET);
          state    <= S_RST_WAIT;
        end
        S_RST_WAIT: if (tmr_free) begin
          if (rst_idx == 2'd3) begin
            set_idx  <= '0;
            cur_byte <= setup_byte(3'd0);
            cur_rs   <= 1'b0;
            src      <= SRC_SETUP;
            state    <= S_HI;
          end else begin
            rst_idx <= rst_idx + 1'b1;
            state   <= S_RST_NIB;
          end
        end
        // pick the byte that follows a completed one
        S_NEXT: begin
          case (src)
            SRC_SETUP: begin
              if (set_idx == 3'(N_SETUP - 1)) begin
                line     <= 1'b0;
                cur_byte <= CMD_DDRAM;
                src      <= SRC_ADDR;
              end else begin
                set_idx  <= set_idx + 1'b1;
                cur_byte <= setup_byte(set_idx + 1'b1);
              end
              cur_rs <= 1'b0;
              state  <= S_HI;
            end
            SRC_ADDR: begin col <= '0;        state <= S_FETCH; end
            SRC_TEXT: begin col <= col + 1'b1; state <= S_FETCH; end
            default:  begin done <= 1'b1;     state <= S_READY; end
          endcase
        end
        S_FETCH: state <= (col == (COL_W+1)'(LINE_LEN)) ? S_LINE_END : S_FETCH_W;
        S_FETCH_W: begin
          if (rd_byte == 8'h00) begin
            state <= S_LINE_END;
          end else begin
            cur_byte <= rd_byte;
            cur_rs   <= 1'b1;
            src      <= SRC_TEXT;
            state    <= S_HI;
          end
        end
        S_LINE_END: begin
          if (!line) begin
            line     <= 1'b1;
            cur_byte <= CMD_DDRAM | {1'b0, LINE1_BASE};
            cur_rs   <= 1'b0;
            src      <= SRC_ADDR;
            state    <= S_HI;
          end else begin
            done  <= 1'b1;
            state <= S_READY;
          end
        end
        // byte transfer: upper half, gap, lower half
        S_HI: begin
          nb_req <= 1'b1; nb_rd <= 1'b0; nb_rs <= cur_rs;
          nb_wnib <= cur_byte[7:4];
          state <= S_HI_ACK;
        end
        S_HI_ACK: if (nb_ack) begin
          tmr_load <= 1'b1; tmr_val <= TW'(T_GAP); state <= S_GAP;
        end
        S_GAP: if (tmr_free) begin
          nb_req <= 1'b1; nb_rd <= 1'b0; nb_rs <= cur_rs;
          nb_wnib <= cur_byte[3:0];
          state <= S_LO_ACK;
        end
        S_LO_ACK: if (nb_ack) begin
          tmr_load <= 1'b1; tmr_val <= TW'(T_SET);
          poll_cnt <= '0;
          state    <= S_WAIT;
        end
        // bounded status poll, two reads per poll
        S_WAIT: if (tmr_free) begin
          nb_req <= 1'b1; nb_rd <= 1'b1; nb_rs <= 1'b0;
          state  <= S_PH_ACK;
        end
        S_PH_ACK: if (nb_ack) begin
          stat_busy <= nb_rnib[3];
          nb_req <= 1'b1; nb_rd <= 1'b1; nb_rs <= 1'b0;
          state  <= S_PL_ACK;
        end
        S_PL_ACK: if (nb_ack) begin
          if (!stat_busy) begin
            state <= S_NEXT;
          end else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            nb_req <= 1'b1; nb_rd <= 1'b1; nb_rs <= 1'b0;
            state  <= S_PH_ACK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // no read strobe during the blind power-up train (R2)
  p_no_read_in_train_r2: assert property (@(posedge clk) disable iff (rst)
    (state inside {S_RST_NIB, S_RST_ACK, S_RST_WAIT}) |-> !lcd_rw);
  // settle wait runs out before the first status read (R5)
  p_settle_before_poll_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_PH_ACK && $past(state) == S_WAIT) |-> $past(tmr_zero));
  // error only rises at the end of a status poll (R7)
  p_error_from_poll_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> $past(state) == S_PL_ACK);
  // done never coincides with error (R7)
  p_done_not_error_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !error);
  // done is a single-cycle pulse (R10)
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/test_chardisp_init_seq.sv
module test_chardisp_init_seq;
  localparam int CLK_HZ = 1_000_000;
  localparam int T_LONG = CLK_HZ / 200;
  localparam int T_SET  = CLK_HZ / 10000;
  localparam int T_GAP  = CLK_HZ / 100000;
  localparam int WD_LIMIT = 190_000;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst, start, sleep_req, wake_req, txt_we;
  logic [6:0] txt_addr;
  logic [7:0] txt_wdata;
  logic lcd_en, lcd_rs, lcd_rw, done, error;
  logic [3:0] lcd_dout, lcd_din;

  chardisp_init_seq #(.CLK_HZ(CLK_HZ)) i_chardisp_init_seq (
    .clk(clk), .rst(rst), .start(start), .sleep_req(sleep_req),
    .wake_req(wake_req), .txt_we(txt_we), .txt_addr(txt_addr),
    .txt_wdata(txt_wdata), .lcd_en(lcd_en), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_dout(lcd_dout), .lcd_din(lcd_din), .done(done), .error(error)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard of expected write strobes
  typedef struct packed { logic rs; logic [3:0] nib; logic [15:0] gap; logic last; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic push_nib(input bit rs, input logic [3:0] n, input int gap, input bit last, input string tag);
    exp_t e;
    e.rs = rs; e.nib = n; e.gap = 16'(gap); e.last = last;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic push_byte(input bit rs, input logic [7:0] b, input string tag);
    push_nib(rs, b[7:4], T_SET, 1'b0, tag);
    push_nib(rs, b[3:0], T_GAP, 1'b1, "R4 lower half");
  endtask

  // module model and monitor
  int   busy_cfg = 0, busy_left = 0;
  bit   upper = 1'b1;
  int   cyc = 0, last_wr = 0, wr_run = 0, rd_since_wr = 0, done_cnt = 0;
  bit   en_prev = 1'b0, done_prev = 1'b0, rise_rd = 1'b0, wd = 1'b0, first_wr = 1'b1;
  exp_t got;
  string gtag;

  assign lcd_din = upper ? ((busy_left > 0) ? 4'hF : 4'h7) : 4'hF;

  always @(negedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) wd = 1'b1;
    if (!rst) begin
      if (lcd_en && !en_prev) begin
        rise_rd = lcd_rw;
        if (!lcd_rw) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected write strobe", {lcd_rs, lcd_dout}, 0);
          end else begin
            got  = exp_q.pop_front();
            gtag = tag_q.pop_front();
            chk({lcd_rs, lcd_dout} == {got.rs, got.nib}, gtag, {lcd_rs, lcd_dout}, {got.rs, got.nib});
            if (!first_wr)
              chk((cyc - last_wr) >= int'(got.gap), {gtag, " R4 gap"}, cyc - last_wr, int'(got.gap));
            if (got.last) busy_left = busy_cfg;
          end
          first_wr = 1'b0;
          last_wr  = cyc;
          wr_run++;
          rd_since_wr = 0;
          upper = 1'b1;
        end else begin
          rd_since_wr++;
          if (wr_run < 4) chk(1'b0, "R2 read during power-up train", wr_run, 4);
          if (lcd_rs) chk(1'b0, "R5 status read with select 1", 1, 0);
        end
      end
      if (!lcd_en && en_prev && rise_rd) begin
        if (upper) upper = 1'b0;
        else begin
          upper = 1'b1;
          if (busy_left > 0) busy_left--;
        end
      end
      if (done) begin
        done_cnt++;
        if (done_prev) chk(1'b0, "R10 done wider than one cycle", 2, 1);
      end
    end
    en_prev   = lcd_en;
    done_prev = done;
  end

  byte unsigned l0[$], l1[$];

  task automatic load_line(input bit ln, input byte unsigned q[$]);
    for (int i = 0; i < q.size() && i < 40; i++) begin
      @(negedge clk); txt_we = 1'b1; txt_addr = {ln, 6'(i)}; txt_wdata = q[i];
    end
    if (q.size() < 40) begin
      @(negedge clk); txt_we = 1'b1; txt_addr = {ln, 6'(q.size())}; txt_wdata = 8'h00;
    end
    @(negedge clk); txt_we = 1'b0;
  endtask

  task automatic push_line(input logic [7:0] addr_cmd, input byte unsigned q[$]);
    push_byte(1'b0, addr_cmd, "R8 line address command");
    for (int i = 0; i < q.size() && i < 40; i++) push_byte(1'b1, q[i], "R8 R9 text character");
  endtask

  task automatic wait_end();
    while (!done && !error && !wd) @(negedge clk);
  endtask

  task automatic run_seq(input int busy, input bit expect_err, input string name);
    load_line(1'b0, l0);
    load_line(1'b1, l1);
    exp_q.delete(); tag_q.delete();
    push_nib(1'b0, 4'h3, 0,      1'b0, "R2 first train nibble");
    push_nib(1'b0, 4'h3, T_LONG, 1'b0, "R2 second train nibble");
    push_nib(1'b0, 4'h3, T_SET,  1'b0, "R2 third train nibble");
    push_nib(1'b0, 4'h2, T_SET,  1'b0, "R2 nibble-mode switch");
    if (expect_err) begin
      push_byte(1'b0, 8'h28, "R3 setup byte");
    end else begin
      push_byte(1'b0, 8'h28, "R3 setup 0x28");
      push_byte(1'b0, 8'h0C, "R3 setup 0x0C");
      push_byte(1'b0, 8'h06, "R3 setup 0x06");
      push_byte(1'b0, 8'h01, "R3 setup 0x01");
      push_byte(1'b0, 8'h02, "R3 setup 0x02");
      push_line(8'h80, l0);
      push_line(8'hA8, l1);
    end
    busy_cfg = busy; wr_run = 0; done_cnt = 0; first_wr = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(error == 1'b0, {name, " R7 error cleared by start"}, error, 0);
    wait_end();
    if (expect_err) begin
      chk(error == 1'b1, {name, " R7 error raised"}, error, 1);
      chk(rd_since_wr == 100, {name, " R7 reads before giving up"}, rd_since_wr, 100);
      repeat (300) @(negedge clk);
      chk(done_cnt == 0, {name, " R7 no done after timeout"}, done_cnt, 0);
      chk(error == 1'b1, {name, " R7 error held"}, error, 1);
    end else begin
      chk(done == 1'b1 && error == 1'b0, {name, " R10 done reached"}, {done, error}, 2);
      chk(rd_since_wr == 2 * (busy + 1), {name, " R6 R10 polls before done"}, rd_since_wr, 2 * (busy + 1));
      repeat (20) @(negedge clk);
      chk(done_cnt == 1, {name, " R10 single done pulse"}, done_cnt, 1);
    end
    chk(exp_q.size() == 0, {name, " R3 R8 all expected strobes seen"}, exp_q.size(), 0);
  endtask

  task automatic pwr_cmd(input bit sleep, input string name);
    exp_q.delete(); tag_q.delete();
    push_byte(1'b0, sleep ? 8'h08 : 8'h0C, "R11 power command");
    busy_cfg = 2; done_cnt = 0;
    @(negedge clk); sleep_req = sleep; wake_req = !sleep;
    @(negedge clk); sleep_req = 1'b0; wake_req = 1'b0;
    wait_end();
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, {name, " R11 done after power command"}, done_cnt, 1);
    chk(exp_q.size() == 0, {name, " R11 command sent"}, exp_q.size(), 0);
    chk(rd_since_wr == 6, {name, " R11 status polled"}, rd_since_wr, 6);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    txt_we = 1'b0; txt_addr = '0; txt_wdata = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    chk(lcd_en == 1'b0 && done == 1'b0 && error == 1'b0, "R1 idle after reset", {lcd_en, done, error}, 0);
    chk(wr_run == 0 && rd_since_wr == 0, "R1 no bus cycle without start", wr_run, 0);

    // short line 0, full line 1 without terminator
    l0 = '{8'h48, 8'h69};
    l1.delete();
    for (int i = 0; i < 40; i++) l1.push_back(8'(8'h61 + (i % 26)));
    if (!wd) run_seq(0, 1'b0, "run_a");
    if (!wd) pwr_cmd(1'b1, "sleep");
    if (!wd) pwr_cmd(1'b0, "wake");

    // empty line 0, busy three polls
    l0.delete(); l1 = '{8'h4F, 8'h6B};
    if (!wd) run_seq(3, 1'b0, "run_b");

    // busy until the last allowed poll
    l0 = '{8'h41}; l1 = '{8'h42};
    if (!wd) run_seq(49, 1'b0, "run_c");

    // never clears: timeout
    if (!wd) run_seq(50, 1'b1, "run_d");

    // restart after error, empty line 1
    l0 = '{8'h5A}; l1.delete();
    if (!wd) run_seq(0, 1'b0, "run_e");

    if (wd) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule